// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor leaves normal execution and enters debug mode. Two things can start an entry. One is a falling edge on a shared, active-low debug-event line, which is synchronised before use. The other is a breakpoint match from the core. Entry is not immediate. The controller first asks the core to stall and waits for the current instruction to complete. It then asks for the pipeline state to be saved and waits for that save to finish. Only then does it raise the debug-mode flag.

On entry, the controller pulls the shared line low for a fixed number of cycles as an acknowledge. It does this only through an open-drain pull enable, and an external pull-up returns the line high. Debug mode lasts until the serial debug command path issues an exit, and the block then goes back to the run state. While entry is under way or debug mode is active, further requests are absorbed. The block's own acknowledge pulse never counts as a new request.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While rst_ni is low, stall_req_o, save_req_o, debug_mode_o and de_pull_en_o are all 0, and the same holds in the first cycle after release.
- R2: A high-to-low transition of de_pin_i, seen in the run state, raises stall_req_o. If the pin is first sampled low at clock edge N, stall_req_o is 1 after edge N+2.
- R3: A breakpoint_i sampled at 1 in the run state raises stall_req_o after that same edge.
- R4: save_req_o rises only at the edge after instr_done_i is sampled at 1 while stalling. stall_req_o stays 1 throughout entry and debug mode.
- R5: When save_done_i is sampled at 1 while save_req_o is 1, then after that edge debug_mode_o becomes 1 and save_req_o becomes 0.
- R6: de_pull_en_o is 1 for exactly PULSE_LEN cycles (default 3), starting in the first cycle that debug_mode_o is 1, and it is 0 at all other times. The block only enables a pull-low and never drives the line high.
- R7: debug_mode_o stays 1 until exit_cmd_i is sampled at 1. After that edge, debug_mode_o and stall_req_o are 0.
- R8: A breakpoint or pin request arriving at the same edge as another request, during entry, or during debug mode produces no extra entry and no extra pulse.
- R9: Edges on de_pin_i are ignored as requests while de_pull_en_o is 1. The block's own pulse therefore does not restart entry, even after an exit made during the pulse.
- R10: instr_done_i and save_done_i have no effect in the run state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_pin_i | input | 1 | Level of the shared debug-event line (low = active) |
| breakpoint_i | input | 1 | Breakpoint match from the core |
| instr_done_i | input | 1 | Core reports that the current instruction has completed |
| save_done_i | input | 1 | Core reports that the pipeline save has finished |
| exit_cmd_i | input | 1 | Exit command from the debug command path |
| stall_req_o | output | 1 | Request that the core stall |
| save_req_o | output | 1 | Request that the pipeline state be saved |
| debug_mode_o | output | 1 | Debug mode is active |
| de_pull_en_o | output | 1 | Open-drain enable that pulls the debug-event line low |

## Verification
Handshake inputs and breakpoints are reflected in the registered outputs one edge after they are sampled. A pin falling edge takes three edges because of the two synchroniser stages and the edge detector. The acknowledge pulse starts at the same edge that sets the debug flag and, after an exit, ends on its own count. The bench drives each stimulus at a falling clock edge and queues the value expected after the next rising edge. A monitor compares that value 5 ns after the rising edge. Stimuli that take effect later are therefore checked across the intervening cycles, with the expected values held at their old level until the due edge.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STALL = 2'd1,
    ST_SAVE  = 2'd2,
    ST_DEBUG = 2'd3
  } dbg_state_e;
endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;
  logic [DEPTH-1:0] chain_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  // last stage is a delayed copy used only for edge detection
  assign fall_o = chain_q[DEPTH-1] & ~chain_q[DEPTH-2];
endmodule

// File: rtl/dbg_ack_pulse.sv
module dbg_ack_pulse #(
  parameter int unsigned PULSE_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pull_en_o
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;

  assign pull_en_o = (cnt_q != '0);

  // independent length checker
  logic [CW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        run_q <= '0;
    else if (pull_en_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;

  a_r6_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_en_o) |-> run_q == (CW+1)'(PULSE_LEN));
  a_r6_start_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pull_en_o);
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_fall_i,
  input  logic pin_mask_i,
  input  logic bkpt_i,
  input  logic instr_done_i,
  input  logic save_done_i,
  input  logic exit_i,
  output logic stall_o,
  output logic save_o,
  output logic debug_o,
  output logic enter_o
);
  dbg_state_e state_q, state_d;
  logic req;

  assign req = (pin_fall_i & ~pin_mask_i) | bkpt_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (req)          state_d = ST_STALL;
      ST_STALL: if (instr_done_i) state_d = ST_SAVE;
      ST_SAVE:  if (save_done_i)  state_d = ST_DEBUG;
      ST_DEBUG: if (exit_i)       state_d = ST_RUN;
      default:                    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;

  assign stall_o = (state_q != ST_RUN);
  assign save_o  = (state_q == ST_SAVE);
  assign debug_o = (state_q == ST_DEBUG);
  assign enter_o = (state_q == ST_SAVE) & save_done_i;

  a_r4_save_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(save_o) |-> $past(instr_done_i) && $past(stall_o));
  a_r5_debug_after_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(debug_o) |-> $past(save_o) && $past(save_done_i));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_o && !exit_i |=> debug_o);
  a_r7_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_o && exit_i |=> !stall_o && !debug_o);
  a_r10_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o && !bkpt_i && !(pin_fall_i && !pin_mask_i) |=> !stall_o);
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_LEN   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic de_pin_i,
  input  logic breakpoint_i,
  input  logic instr_done_i,
  input  logic save_done_i,
  input  logic exit_cmd_i,
  output logic stall_req_o,
  output logic save_req_o,
  output logic debug_mode_o,
  output logic de_pull_en_o
);
  logic pin_fall, enter;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (de_pin_i),
    .fall_o (pin_fall)
  );

  dbg_entry_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_fall_i   (pin_fall),
    .pin_mask_i   (de_pull_en_o),
    .bkpt_i       (breakpoint_i),
    .instr_done_i (instr_done_i),
    .save_done_i  (save_done_i),
    .exit_i       (exit_cmd_i),
    .stall_o      (stall_req_o),
    .save_o       (save_req_o),
    .debug_o      (debug_mode_o),
    .enter_o      (enter)
  );

  dbg_ack_pulse #(.PULSE_LEN(PULSE_LEN)) u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (enter),
    .pull_en_o (de_pull_en_o)
  );

  a_r6_pulse_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(debug_mode_o) |-> de_pull_en_o);
  a_r8_pulse_only_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_pull_en_o) |-> $rose(debug_mode_o));
  a_r4_stall_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o || debug_mode_o) |-> stall_req_o);
endmodule

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_low = 1'b0;
  logic bkpt = 1'b0, idone = 1'b0, sdone = 1'b0, exit_cmd = 1'b0;
  logic stall, save, dbg, pull;
  logic de_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  // open-drain line with pull-up
  assign de_line = ~(ext_low | pull);

  dbg_entry_ctrl u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .de_pin_i     (de_line),
    .breakpoint_i (bkpt),
    .instr_done_i (idone),
    .save_done_i  (sdone),
    .exit_cmd_i   (exit_cmd),
    .stall_req_o  (stall),
    .save_req_o   (save),
    .debug_mode_o (dbg),
    .de_pull_en_o (pull)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stall/save/dbg/pull actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: set inputs at negedge, queue value expected after next posedge
  task automatic cyc(input logic el, input logic bk, input logic id, input logic sd,
                     input logic ex, input logic [3:0] exp, input string tag);
    @(negedge clk);
    ext_low = el; bkpt = bk; idone = id; sdone = sd; exit_cmd = ex;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() != 0) check({stall, save, dbg, pull}, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 check({stall, save, dbg, pull}, 4'b0000, "R1 in reset");
    @(negedge clk) rst_ni = 1'b1;
    cyc(0,0,0,0,0, 4'b0000, "R1 after release");
    // R10: handshakes in run ignored
    cyc(0,0,1,1,0, 4'b0000, "R10 done in run");
    cyc(0,0,0,0,0, 4'b0000, "R10 idle");
    // breakpoint entry
    cyc(0,1,0,0,0, 4'b1000, "R3 breakpoint stall");
    cyc(0,0,0,0,0, 4'b1000, "R4 wait instr");
    cyc(0,0,1,0,0, 4'b1100, "R4 save req");
    cyc(0,0,0,0,0, 4'b1100, "R5 wait save");
    cyc(0,0,0,1,0, 4'b1011, "R5 debug set");
    cyc(0,0,0,0,0, 4'b1011, "R6 pulse 2");
    cyc(0,0,0,0,0, 4'b1011, "R6 pulse 3");
    cyc(0,0,0,0,0, 4'b1010, "R6 pulse end");
    cyc(0,1,0,0,0, 4'b1010, "R8 bkpt in debug");
    cyc(0,0,0,0,0, 4'b1010, "R7 hold");
    cyc(0,0,0,0,1, 4'b0000, "R7 exit");
    cyc(0,0,0,0,0, 4'b0000, "R9 idle");
    cyc(0,0,0,0,0, 4'b0000, "R9 idle");
    // pin entry
    cyc(1,0,0,0,0, 4'b0000, "R2 sync 1");
    cyc(1,0,0,0,0, 4'b0000, "R2 sync 2");
    cyc(1,0,0,0,0, 4'b1000, "R2 pin stall");
    cyc(1,1,0,0,0, 4'b1000, "R8 bkpt in stall");
    cyc(0,0,1,0,0, 4'b1100, "R4 save after pin");
    cyc(0,1,0,1,0, 4'b1011, "R8 bkpt in save");
    cyc(0,0,0,0,0, 4'b1011, "R6 pulse 2");
    cyc(0,0,0,0,0, 4'b1011, "R6 pulse 3");
    cyc(0,0,0,0,0, 4'b1010, "R6 pulse end");
    cyc(1,0,0,0,0, 4'b1010, "R8 pin in debug");
    cyc(0,0,0,0,0, 4'b1010, "R8 pin in debug");
    cyc(0,0,0,0,0, 4'b1010, "R8 pin in debug");
    cyc(0,0,0,0,0, 4'b1010, "R8 settle");
    cyc(0,0,0,0,1, 4'b0000, "R7 exit");
    cyc(0,0,0,0,0, 4'b0000, "R8 no second entry");
    cyc(0,0,0,0,0, 4'b0000, "R8 no second entry");
    cyc(0,0,0,0,0, 4'b0000, "R8 no second entry");
    // coincident pin fall and breakpoint, exit during pulse
    cyc(1,0,0,0,0, 4'b0000, "R8 sync 1");
    cyc(1,0,0,0,0, 4'b0000, "R8 sync 2");
    cyc(1,1,0,0,0, 4'b1000, "R8 coincident");
    cyc(0,0,1,0,0, 4'b1100, "R8 single save");
    cyc(0,0,0,1,0, 4'b1011, "R6 pulse 1");
    cyc(0,0,0,0,1, 4'b0001, "R9 exit in pulse");
    cyc(0,0,0,0,0, 4'b0001, "R6 pulse 3 after exit");
    cyc(0,0,0,0,0, 4'b0000, "R9 no retrigger");
    cyc(0,0,0,0,0, 4'b0000, "R9 no retrigger");
    cyc(0,0,0,0,0, 4'b0000, "R9 no retrigger");
    cyc(0,0,0,0,0, 4'b0000, "R9 no retrigger");
    // async reset mid entry
    cyc(0,1,0,0,0, 4'b1000, "R3 breakpoint again");
    @(negedge clk) bkpt = 1'b0; rst_ni = 1'b0;
    #2 check({stall, save, dbg, pull}, 4'b0000, "R1 async reset");
    @(negedge clk) rst_ni = 1'b1;
    cyc(0,0,0,0,0, 4'b0000, "R1 after second release");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule